// File: doc/BRIEF.md
# Multi-Category Wavefront Issue Arbiter

This block picks, every clock cycle, which resident wavefronts of one SIMD may issue an instruction. Each wavefront slot shows three things: a valid flag, a ready flag and a 3-bit operation code. The block turns each code into an issue category. It then grants at most one wavefront per category and never grants the same wavefront twice in one cycle. It can therefore send several instructions of different kinds at once, for example a scalar op from one wavefront and a vector op from another.

Inside each category the choice is fair. A rotating pointer per category marks where the search begins. A busy input per category holds that category back for the cycle. A global limit caps how many grants leave in one cycle, and when the limit applies the categories with lower codes are served first. Each grant appears one cycle after its inputs, as a valid bit plus a wavefront index.

Floating-point, integer and transcendental vector ops all share the single vector ALU category. A transcendental op takes the vector slot for its grant cycle only. The arbiter keeps no state about it, so the vector slot is free again in the next cycle.

Top module: `wave_issue_arb`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every `gnt_valid` bit is 0. All rotating pointers restart at wavefront 0.
- R2: Operation codes 0 to 6 map to categories of the same number: 0 branch, 1 scalar ALU, 2 vector ALU, 3 vector memory, 4 local data share, 5 export/global data share, 6 special. Code 7 (transcendental) maps to category 2.
- R3: A grant on category c names a wavefront that had valid=1, ready=1 and an operation code mapping to c in the previous cycle. At most one wavefront is granted per category.
- R4: No wavefront index appears on two asserted grants in the same cycle.
- R5: Within a category, the search starts at that category's pointer and runs upward through the indices, wrapping modulo NUM_WAVES. After a grant the pointer becomes (granted index + 1) mod NUM_WAVES.
- R6: When `cat_busy[c]` is high, category c gives no grant for that cycle and its pointer stays where it was.
- R7: No more than MAX_GRANTS (default 5) grants are asserted in one cycle. Categories are served in ascending code order, so those with higher codes lose their grant first.
- R8: Grants are registered. They reflect the inputs of the cycle before, and a cycle with no valid wavefront gives no grant.
- R9: A transcendental grant does not block the vector ALU category in the next cycle.
- R10: A scalar op and a vector op from two different wavefronts are both granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wv_valid | input | NUM_WAVES | Slot holds a resident wavefront with an instruction |
| wv_ready | input | NUM_WAVES | Wavefront instruction is ready to issue |
| wv_code | input | NUM_WAVES*3 | Operation code per wavefront, slot w at bits [3w+2:3w] |
| cat_busy | input | 7 | Per-category hold-off, bit c for category c |
| gnt_valid | output | 7 | Per-category grant valid |
| gnt_idx | output | 7*IDX_W | Granted wavefront index, category c at bits [c*IDX_W +: IDX_W] |

## Verification
Two situations are hard to reach from the ports. The first is the grant cap, which needs more categories requesting at once than the limit allows. The second is the wrap of a rotating pointer, which happens only after a particular history of grants. A directed step places seven wavefronts across all seven categories, so that exactly the two highest categories lose their grant. A pointer-rotation step alternates two requesters in one category. A long pseudo-random sweep with random busy bits follows, in which a bench model of the pointers predicts every grant cycle by cycle, so wrap-arounds and lost grants under busy come up many times.

// File: rtl/wia_pkg.sv
package wia_pkg;
  localparam int CAT_N  = 7;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    OP_BRANCH  = 3'd0,
    OP_SCALAR  = 3'd1,
    OP_VALU    = 3'd2,
    OP_VMEM    = 3'd3,
    OP_LDS     = 3'd4,
    OP_EXPORT  = 3'd5,
    OP_SPECIAL = 3'd6,
    OP_TRANS   = 3'd7
  } op_code_e;

  // transcendental ops share the vector ALU issue slot
  function automatic logic [CODE_W-1:0] cat_of(input logic [CODE_W-1:0] code);
    return (code == OP_TRANS) ? OP_VALU : code;
  endfunction
endpackage

// File: rtl/wia_elig.sv
module wia_elig
  import wia_pkg::*;
#(
  parameter int NUM_WAVES = 10
) (
  input  logic [NUM_WAVES-1:0]        wv_valid,
  input  logic [NUM_WAVES-1:0]        wv_ready,
  input  logic [NUM_WAVES*CODE_W-1:0] wv_code,
  output logic [CAT_N-1:0][NUM_WAVES-1:0] req
);
  for (genvar c = 0; c < CAT_N; c++) begin : g_cat
    for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
      assign req[c][w] = wv_valid[w] && wv_ready[w] &&
                         (cat_of(wv_code[w*CODE_W +: CODE_W]) == CODE_W'(c));
    end
  end
endmodule

// File: rtl/wia_rr_pick.sv
module wia_rr_pick #(
  parameter int N  = 10,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  int j;
  always_comb begin
    hit = 1'b0;
    idx = '0;
    j   = 0;
    for (int i = 0; i < N; i++) begin
      j = (int'(ptr) + i) % N;
      if (!hit && req[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/wave_issue_arb.sv
module wave_issue_arb
  import wia_pkg::*;
#(
  parameter int NUM_WAVES  = 10,
  parameter int MAX_GRANTS = 5,
  parameter int IDX_W      = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_WAVES-1:0]        wv_valid,
  input  logic [NUM_WAVES-1:0]        wv_ready,
  input  logic [NUM_WAVES*CODE_W-1:0] wv_code,
  input  logic [CAT_N-1:0]            cat_busy,
  output logic [CAT_N-1:0]            gnt_valid,
  output logic [CAT_N*IDX_W-1:0]      gnt_idx
);
  localparam int CNT_W = $clog2(CAT_N + 1);

  logic [CAT_N-1:0][NUM_WAVES-1:0] req;
  logic [CAT_N-1:0][IDX_W-1:0]     ptr_q;
  logic [CAT_N-1:0][IDX_W-1:0]     pick_idx;
  logic [CAT_N-1:0]                pick_hit;
  logic [CAT_N-1:0]                fire;
  logic [NUM_WAVES-1:0]            taken;
  logic [CNT_W-1:0]                used;

  wia_elig #(.NUM_WAVES(NUM_WAVES)) u_elig (
    .wv_valid (wv_valid),
    .wv_ready (wv_ready),
    .wv_code  (wv_code),
    .req      (req)
  );

  for (genvar c = 0; c < CAT_N; c++) begin : g_pick
    wia_rr_pick #(.N(NUM_WAVES), .IW(IDX_W)) u_pick (
      .req (req[c]),
      .ptr (ptr_q[c]),
      .hit (pick_hit[c]),
      .idx (pick_idx[c])
    );
  end

  // resolve categories in ascending order: busy, cap, wave uniqueness
  always_comb begin
    taken = '0;
    used  = '0;
    fire  = '0;
    for (int c = 0; c < CAT_N; c++) begin
      if (pick_hit[c] && !cat_busy[c] && (int'(used) < MAX_GRANTS) &&
          !taken[pick_idx[c]]) begin
        fire[c]             = 1'b1;
        taken[pick_idx[c]]  = 1'b1;
        used                = used + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= '0;
      gnt_idx   <= '0;
      ptr_q     <= '0;
    end else begin
      for (int c = 0; c < CAT_N; c++) begin
        gnt_valid[c]                <= fire[c];
        gnt_idx[c*IDX_W +: IDX_W]   <= fire[c] ? pick_idx[c] : '0;
        if (fire[c])
          ptr_q[c] <= (int'(pick_idx[c]) == NUM_WAVES - 1) ? '0 : pick_idx[c] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wia_chk.sv
module wia_chk
  import wia_pkg::*;
#(
  parameter int NUM_WAVES  = 10,
  parameter int MAX_GRANTS = 5,
  parameter int IDX_W      = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_WAVES-1:0]        wv_valid,
  input logic [NUM_WAVES-1:0]        wv_ready,
  input logic [NUM_WAVES*CODE_W-1:0] wv_code,
  input logic [CAT_N-1:0]            cat_busy,
  input logic [CAT_N-1:0]            gnt_valid,
  input logic [CAT_N*IDX_W-1:0]      gnt_idx
);
  logic [NUM_WAVES-1:0] elig [CAT_N];
  always_comb begin
    for (int c = 0; c < CAT_N; c++)
      for (int w = 0; w < NUM_WAVES; w++)
        elig[c][w] = wv_valid[w] && wv_ready[w] &&
                     (cat_of(wv_code[w*CODE_W +: CODE_W]) == CODE_W'(c));
  end

  AST_GRANT_CAP: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt_valid) <= MAX_GRANTS); // R7

  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
    ($past(wv_valid) == '0) |-> (gnt_valid == '0)); // R8

  for (genvar c = 0; c < CAT_N; c++) begin : g_cat
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
      gnt_valid[c] |-> !$past(cat_busy[c])); // R6

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
      gnt_valid[c] |-> (int'(gnt_idx[c*IDX_W +: IDX_W]) < NUM_WAVES)); // R3

    AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (rst)
      gnt_valid[c] |-> $past(elig[c]) [gnt_idx[c*IDX_W +: IDX_W]]); // R3

    for (genvar d = c + 1; d < CAT_N; d++) begin : g_pair
      AST_ONE_PER_WAVE: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid[c] && gnt_valid[d]) |->
          (gnt_idx[c*IDX_W +: IDX_W] != gnt_idx[d*IDX_W +: IDX_W])); // R4
    end
  end
endmodule

bind wave_issue_arb wia_chk #(
  .NUM_WAVES(NUM_WAVES), .MAX_GRANTS(MAX_GRANTS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .wv_valid(wv_valid), .wv_ready(wv_ready),
  .wv_code(wv_code), .cat_busy(cat_busy), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
);

// File: tb/test_wave_issue_arb.sv
`timescale 1ns/1ps
module test_wave_issue_arb;
  localparam int N    = 10;
  localparam int CATS = 7;
  localparam int MAXG = 5;
  localparam int IW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]      wv_valid = '0;
  logic [N-1:0]      wv_ready = '0;
  logic [N*3-1:0]    wv_code  = '0;
  logic [CATS-1:0]   cat_busy = '0;
  logic [CATS-1:0]   gnt_valid;
  logic [CATS*IW-1:0] gnt_idx;

  int checks = 0;
  int fails  = 0;
  int mptr [CATS];
  bit exp_v [CATS];
  int exp_i [CATS];

  always #5 clk = ~clk;

  wave_issue_arb #(.NUM_WAVES(N), .MAX_GRANTS(MAXG)) i_wave_issue_arb (
    .clk(clk), .rst(rst), .wv_valid(wv_valid), .wv_ready(wv_ready),
    .wv_code(wv_code), .cat_busy(cat_busy), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gidx(input int c);
    return int'(gnt_idx[c*IW +: IW]);
  endfunction

  task automatic set_wave(input int w, input int code);
    wv_valid[w] = 1'b1;
    wv_ready[w] = 1'b1;
    wv_code[w*3 +: 3] = 3'(code);
  endtask

  task automatic clr();
    wv_valid = '0; wv_ready = '0; wv_code = '0; cat_busy = '0;
  endtask

  // model: category mapping (R2), rotating search (R5), busy (R6), cap (R7)
  task automatic predict();
    bit used_w [N];
    int cnt = 0;
    for (int w = 0; w < N; w++) used_w[w] = 1'b0;
    for (int c = 0; c < CATS; c++) begin
      int found = -1;
      for (int i = 0; i < N; i++) begin
        int j = (mptr[c] + i) % N;
        int code = int'(wv_code[j*3 +: 3]);
        int cat = (code == 7) ? 2 : code;
        if (found < 0 && wv_valid[j] && wv_ready[j] && cat == c && !used_w[j]) found = j;
      end
      exp_v[c] = (found >= 0) && !cat_busy[c] && (cnt < MAXG);
      exp_i[c] = exp_v[c] ? found : 0;
      if (exp_v[c]) begin
        used_w[found] = 1'b1;
        cnt++;
        mptr[c] = (found + 1) % N;
      end
    end
  endtask

  // one cycle: predict, let the edge register, compare at the next falling edge (R3 R8)
  task automatic cyc();
    predict();
    @(negedge clk);
    for (int c = 0; c < CATS; c++) begin
      check(gnt_valid[c] == exp_v[c], "R3 grant valid", int'(gnt_valid[c]), int'(exp_v[c]));
      if (exp_v[c]) check(gidx(c) == exp_i[c], "R5 grant index", gidx(c), exp_i[c]);
    end
  endtask

  initial begin
    for (int c = 0; c < CATS; c++) mptr[c] = 0;
    repeat (3) @(negedge clk);
    check(gnt_valid == '0, "R1 reset clear", int'(gnt_valid), 0);
    rst = 1'b0;
    clr();
    cyc();
    check(gnt_valid == '0, "R1 R8 idle no grant", int'(gnt_valid), 0);

    // transcendental in vector slot plus scalar from another wave
    set_wave(2, 7); set_wave(5, 1);
    cyc();
    check(gnt_valid[2] && gidx(2) == 2, "R2 trans maps to valu", gidx(2), 2);
    check(gnt_valid[1] && gidx(1) == 5, "R10 scalar with vector", gidx(1), 5);
    clr(); set_wave(2, 2);
    cyc();
    check(gnt_valid[2] && gidx(2) == 2, "R9 valu free after trans", int'(gnt_valid[2]), 1);

    // rotation within LDS category
    clr(); set_wave(0, 4); set_wave(3, 4);
    cyc(); check(gidx(4) == 0, "R5 first pick", gidx(4), 0);
    cyc(); check(gidx(4) == 3, "R5 rotate", gidx(4), 3);
    cyc(); check(gidx(4) == 0, "R5 wrap", gidx(4), 0);

    // busy holds grant and pointer (pointer sits at 1)
    cat_busy[4] = 1'b1;
    cyc(); check(!gnt_valid[4], "R6 busy blocks", int'(gnt_valid[4]), 0);
    cat_busy[4] = 1'b0;
    cyc(); check(gnt_valid[4] && gidx(4) == 3, "R6 pointer held", gidx(4), 3);

    // all seven categories request: cap drops the two highest
    clr();
    for (int w = 0; w < CATS; w++) set_wave(w, w);
    cyc();
    check(gnt_valid == 7'b0011111, "R7 grant cap order", int'(gnt_valid), 31);

    // pseudo-random sweep
    for (int k = 0; k < 4000; k++) begin
      wv_valid = N'($urandom);
      wv_ready = N'($urandom) | N'($urandom);
      wv_code  = (N*3)'({$urandom, $urandom});
      cat_busy = CATS'($urandom) & CATS'($urandom);
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000ns;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule